// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns data words into asynchronous serial frames on a single output line. Each frame is a low start bit, then 5 to 9 data bits in either bit order, then an optional parity bit, then a stop period of one, one and a half or two bit times. Bit timing comes from a runtime oversample count: each bit lasts that many core clock cycles.

Words arrive on a valid/ready stream. The block raises `in_ready` only while it is idle and the clear-to-send condition holds. A word is taken on the rising clock edge where `in_valid` and `in_ready` are both high. The producer must hold `in_valid` and `in_data` steady until that edge. During a frame `in_ready` stays low, so the producer is held back until the stop period ends. After each frame the line stays high for at least one further cycle before the next start bit.

The width, bit order, parity mode, stop length and oversample count are read on the edge that takes a word. Changing them during a frame does not affect that frame. The clear-to-send input can be enabled or ignored, and its active level can be chosen. It is only looked at between frames. The clear-to-send input is assumed to be synchronous to `clk`.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is running, `tx_out` is high and `busy` is low.
- R2: The cycle after a word is accepted, `busy` goes high and `tx_out` goes low. The line stays low for exactly one bit time (the start bit).
- R3: The number of data bits sent is `cfg_width`; values below 5 act as 5 and values above 9 act as 9. Only the low `cfg_width` bits of `in_data` are sent.
- R4: With `cfg_msb_first` = 0 the data goes out bit 0 first. With 1 it goes out bit `cfg_width`-1 first.
- R5: `cfg_parity` encodes 0 = none, 1 = even, 2 = odd, and 3 acts as none. When parity is enabled, a parity bit follows the data. For even parity it makes the count of ones over the data bits and the parity bit even; for odd parity it makes that count odd.
- R6: `cfg_stop_halves` gives the stop length in half bits. Values below 2 act as 2 and values above 4 act as 4. The line is high for `floor(halves*ovs/2)` cycles, where a half bit is `floor(ovs/2)` cycles. `busy` falls when that period ends.
- R7: Every full bit lasts `cfg_ovs` clock cycles (`cfg_ovs` >= 2). The count used is the one captured when the word was accepted.
- R8: `in_ready` is high exactly when no frame is running and either `cfg_cts_en` = 0 or `cts_in` equals `cfg_cts_active_high`.
- R9: Once a frame has started, it runs to its end whatever `cts_in` does.
- R10: `in_ready` is low throughout a frame. Two frames are always separated by at least one high idle cycle after the stop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word available on `in_data` |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 9 | Data word, low bits used |
| cfg_width | input | 4 | Data bits per frame (5..9) |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd |
| cfg_stop_halves | input | 3 | Stop length in half bits (2..4) |
| cfg_ovs | input | OVS_W | Clock cycles per bit |
| cfg_cts_en | input | 1 | 1 = gate frame starts on `cts_in` |
| cfg_cts_active_high | input | 1 | Active level of `cts_in` |
| cts_in | input | 1 | Clear-to-send |
| tx_out | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The embedded properties check the following on every cycle:
- an idle line is high;
- a frame opens with a low level;
- the line holds steady between bit boundaries;
- the stop period is high;
- the ready and busy relation holds;
- a frame began only when clear-to-send allowed it;
- the bit timer counts down.

Some behaviour only the bench's scenarios can show: the exact bit order, the parity value, the stop length, the clamping of out-of-range settings, and the fact that a frame ignores clear-to-send and configuration changes made while it runs. For these the bench compares the line, `busy` and `in_ready` against a behavioural per-cycle expectation in every cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } parity_e;

  function automatic logic [3:0] clamp_width(input logic [3:0] w);
    if (w < 4'd5) return 4'd5;
    if (w > 4'd9) return 4'd9;
    return w;
  endfunction

  function automatic logic [2:0] clamp_stop(input logic [2:0] h);
    if (h < 3'd2) return 3'd2;
    if (h > 3'd4) return 3'd4;
    return h;
  endfunction
endpackage

// File: rtl/uart_tx_timer.sv
module uart_tx_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);

  // R7: the bit timer decrements by one per cycle until it expires
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/uart_tx_pack.sv
module uart_tx_pack
  import uart_tx_pkg::*;
#(
  parameter int DW_MAX = 9,
  localparam int PAY_W = DW_MAX + 1,
  localparam int NB_W  = $clog2(PAY_W + 1)
) (
  input  logic [DW_MAX-1:0] data,
  input  logic [3:0]        width,
  input  logic              msb_first,
  input  logic [1:0]        parity,
  output logic [PAY_W-1:0]  payload,
  output logic [NB_W-1:0]   nbits
);
  logic [3:0]        w;
  logic [DW_MAX-1:0] masked;
  logic [DW_MAX-1:0] ordered;
  logic              par_en;
  logic              pbit;

  assign w      = clamp_width(width);
  assign par_en = (parity == PAR_EVEN) || (parity == PAR_ODD);

  for (genvar i = 0; i < DW_MAX; i++) begin : g_bits
    localparam logic [3:0] IDX = 4'(i);
    logic [3:0] mirror;
    assign mirror     = w - 4'd1 - IDX;
    assign masked[i]  = (IDX < w) ? data[i] : 1'b0;
    assign ordered[i] = (IDX < w) ? (msb_first ? data[mirror] : data[i]) : 1'b0;
  end

  assign pbit = (parity == PAR_ODD) ? ~(^masked) : (^masked);

  always_comb begin
    for (int i = 0; i < PAY_W; i++) begin
      if (4'(i) < w && i < DW_MAX) payload[i] = ordered[i];
      else if (4'(i) == w && par_en) payload[i] = pbit;
      else                           payload[i] = 1'b1;
    end
    nbits = NB_W'(w) + NB_W'(par_en);
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int OVS_W  = 8,
  parameter int DW_MAX = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW_MAX-1:0] in_data,
  input  logic [3:0]        cfg_width,
  input  logic              cfg_msb_first,
  input  logic [1:0]        cfg_parity,
  input  logic [2:0]        cfg_stop_halves,
  input  logic [OVS_W-1:0]  cfg_ovs,
  input  logic              cfg_cts_en,
  input  logic              cfg_cts_active_high,
  input  logic              cts_in,
  output logic              tx_out,
  output logic              busy
);
  localparam int PAY_W  = DW_MAX + 1;
  localparam int NB_W   = $clog2(PAY_W + 1);
  localparam int SLOT_W = $clog2(PAY_W + 3);

  logic [PAY_W-1:0]  pay, shreg;
  logic [NB_W-1:0]   nbits;
  logic [SLOT_W-1:0] slots_left;
  logic [OVS_W-1:0]  ovs_q, tmr_val;
  logic [2:0]        stop_h;
  logic              half_pend, tx_q, busy_q, cts_ok;
  logic              accept, bit_end, tmr_load, tmr_done;

  uart_tx_pack #(.DW_MAX(DW_MAX)) pack_i (
    .data(in_data), .width(cfg_width), .msb_first(cfg_msb_first),
    .parity(cfg_parity), .payload(pay), .nbits(nbits)
  );

  uart_tx_timer #(.CW(OVS_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  assign stop_h   = clamp_stop(cfg_stop_halves);
  assign cts_ok   = !cfg_cts_en || (cts_in == cfg_cts_active_high);
  assign in_ready = !busy_q && cts_ok;
  assign accept   = in_valid && in_ready;
  assign bit_end  = busy_q && tmr_done;
  assign tmr_load = accept || (bit_end && (slots_left != '0 || half_pend));

  always_comb begin
    if (accept)                tmr_val = cfg_ovs - OVS_W'(1);
    else if (slots_left != '0) tmr_val = ovs_q - OVS_W'(1);
    else                       tmr_val = (ovs_q >> 1) - OVS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      tx_q       <= 1'b1;
      shreg      <= '1;
      slots_left <= '0;
      half_pend  <= 1'b0;
      ovs_q      <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      tx_q       <= 1'b0;
      shreg      <= pay;
      slots_left <= SLOT_W'(nbits) + SLOT_W'(stop_h >> 1);
      half_pend  <= stop_h[0];
      ovs_q      <= cfg_ovs;
    end else if (bit_end) begin
      if (slots_left != '0) begin
        tx_q       <= shreg[0];
        shreg      <= {1'b1, shreg[PAY_W-1:1]};
        slots_left <= slots_left - SLOT_W'(1);
      end else if (half_pend) begin
        half_pend  <= 1'b0;
      end else begin
        busy_q     <= 1'b0;
      end
    end
  end

  assign tx_out = tx_q;
  assign busy   = busy_q;

  // R1: idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_out);
  // R2: a frame opens with the start level
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_out);
  // R7: the line only moves at a bit boundary
  a_r7_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tmr_done) |=> $stable(tx_out));
  // R6: stop period is high
  a_r6_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slots_left == '0) |-> tx_out);
  // R10: no word is taken while a frame runs
  a_r10_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  // R8: a frame only starts when clear-to-send allowed it
  a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(cfg_cts_en)) |-> ($past(cts_in) == $past(cfg_cts_active_high)));
endmodule

// File: tb/uart_frame_tx_tb_top.sv
`timescale 1ns/100ps
module uart_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic [3:0] cfg_width = 4'd8;
  logic       cfg_msb_first = 1'b0;
  logic [1:0] cfg_parity = 2'd0;
  logic [2:0] cfg_stop_halves = 3'd2;
  logic [7:0] cfg_ovs = 8'd4;
  logic       cfg_cts_en = 1'b0;
  logic       cfg_cts_active_high = 1'b0;
  logic       cts_in = 1'b0;
  logic       tx_out, busy;

  int unsigned n_tests = 0, n_fail = 0;
  bit    exp_q[$];
  bit    exp_busy = 1'b0;
  bit    accepted;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  uart_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_width(cfg_width), .cfg_msb_first(cfg_msb_first),
    .cfg_parity(cfg_parity), .cfg_stop_halves(cfg_stop_halves), .cfg_ovs(cfg_ovs),
    .cfg_cts_en(cfg_cts_en), .cfg_cts_active_high(cfg_cts_active_high),
    .cts_in(cts_in), .tx_out(tx_out), .busy(busy)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void push_frame(logic [8:0] d, int w, bit msb, int par, int sh, int ovs);
    int ones = 0;
    if (w < 5) w = 5;
    if (w > 9) w = 9;
    if (sh < 2) sh = 2;
    if (sh > 4) sh = 4;
    repeat (ovs) exp_q.push_back(1'b0);
    for (int i = 0; i < w; i++) begin
      bit b = msb ? d[w-1-i] : d[i];
      ones += int'(b);
      repeat (ovs) exp_q.push_back(b);
    end
    if (par == 1 || par == 2) begin
      bit p = (par == 1) ? bit'(ones % 2) : bit'(1 - ones % 2);
      repeat (ovs) exp_q.push_back(p);
    end
    repeat ((sh * ovs) / 2) exp_q.push_back(1'b1);
  endfunction

  task automatic step();
    bit cts_ok, exp_tx;
    #1;
    cts_ok = !cfg_cts_en || (cts_in == cfg_cts_active_high);
    chk(in_ready == (!exp_busy && cts_ok), cur_req, "in_ready", in_ready, !exp_busy && cts_ok);
    accepted = in_valid && in_ready;
    if (accepted)
      push_frame(in_data, int'(cfg_width), cfg_msb_first, int'(cfg_parity),
                 int'(cfg_stop_halves), int'(cfg_ovs));
    @(negedge clk);
    exp_tx = 1'b1;
    exp_busy = 1'b0;
    if (exp_q.size() > 0) begin
      exp_tx = exp_q.pop_front();
      exp_busy = 1'b1;
    end
    chk(tx_out == exp_tx, cur_req, "tx_out", tx_out, exp_tx);
    chk(busy == exp_busy, cur_req, "busy", busy, exp_busy);
  endtask

  task automatic send(logic [8:0] d);
    in_valid = 1'b1;
    in_data  = d;
    for (int k = 0; k < 2000; k++) begin
      step();
      if (accepted) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_busy || exp_q.size() > 0) step();
    step();
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(tx_out == 1'b1, "R1", "reset tx_out", tx_out, 1);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    repeat (3) step();

    // R2 and R7: 8 data bits, no parity, LSB first, 4 cycles per bit
    cur_req = "R2";
    send(9'h0A5); drain();
    cur_req = "R7";
    cfg_ovs = 8'd7; send(9'h13C); drain();

    // R4: MSB first
    cur_req = "R4";
    cfg_ovs = 8'd4; cfg_msb_first = 1'b1; send(9'h0B1); drain();
    cfg_width = 4'd6; send(9'h02D); drain();
    cfg_msb_first = 1'b0;

    // R3: narrow and wide widths, out-of-range width values
    cur_req = "R3";
    cfg_width = 4'd5; send(9'h1F3); drain();
    cfg_width = 4'd9; send(9'h1A6); drain();
    cfg_width = 4'd2; send(9'h0FF); drain();
    cfg_width = 4'd15; cfg_msb_first = 1'b1; send(9'h101); drain();
    cfg_msb_first = 1'b0;

    // R5: even, odd and reserved parity
    cur_req = "R5";
    cfg_width = 4'd8; cfg_parity = 2'd1; send(9'h0B7); drain(); send(9'h0B3); drain();
    cfg_parity = 2'd2; send(9'h0B7); drain(); send(9'h000); drain();
    cfg_width = 4'd9; send(9'h1FF); drain();
    cfg_parity = 2'd3; send(9'h055); drain();
    cfg_parity = 2'd0; cfg_width = 4'd8;

    // R6: stop lengths and clamping, odd oversample with half stop
    cur_req = "R6";
    cfg_ovs = 8'd5; cfg_stop_halves = 3'd3; send(9'h0C3); drain();
    cfg_stop_halves = 3'd4; send(9'h03C); drain();
    cfg_ovs = 8'd2; cfg_stop_halves = 3'd3; send(9'h081); drain();
    cfg_stop_halves = 3'd0; send(9'h07E); drain();
    cfg_stop_halves = 3'd7; send(9'h0E7); drain();
    cfg_stop_halves = 3'd2; cfg_ovs = 8'd4;

    // R7: oversample and width changed mid-frame do not affect that frame
    cur_req = "R7";
    cfg_ovs = 8'd6; send(9'h09D);
    repeat (5) step();
    cfg_ovs = 8'd3; cfg_width = 4'd5; cfg_parity = 2'd2;
    drain();
    cfg_width = 4'd8; cfg_parity = 2'd0; cfg_ovs = 8'd4;

    // R10: continuous valid, back-to-back frames with idle gap
    cur_req = "R10";
    send(9'h011); send(9'h0EE); send(9'h05A); drain();

    // R8: active-low CTS held inactive blocks start
    cur_req = "R8";
    cfg_cts_en = 1'b1; cfg_cts_active_high = 1'b0; cts_in = 1'b1;
    in_valid = 1'b1; in_data = 9'h0C9;
    repeat (20) step();
    cts_in = 1'b0;
    send(9'h0C9); drain();
    // R8: active-high polarity
    cfg_cts_active_high = 1'b1;
    in_valid = 1'b1; in_data = 9'h036;
    repeat (10) step();
    cts_in = 1'b1; send(9'h036); drain();
    // R8: CTS ignored when disabled
    cfg_cts_en = 1'b0; cts_in = 1'b0; send(9'h0F0); drain();

    // R9: CTS dropped mid-frame, frame still completes
    cur_req = "R9";
    cfg_cts_en = 1'b1; cts_in = 1'b1; send(9'h0A3);
    repeat (6) step();
    cts_in = 1'b0;
    drain();
    repeat (5) step();
    cfg_cts_en = 1'b0;
    repeat (3) step();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule